// File: doc/BRIEF.md
# Subtractive GCD Engine with Moore Control Unit

This block finds the greatest common divisor of two unsigned, nonzero operands by repeated subtraction. It holds two working registers and a small arithmetic unit that can pass an operand through or subtract one operand from the other. The arithmetic unit also reports the sign of its result as a two-bit code. A Moore control machine drives the register selects, the write enables and the arithmetic opcode.

A run begins with a one-cycle start pulse while the engine is idle. The control machine then loads both operands. It compares the registers through the sign code and writes the difference into whichever register holds the larger value. Every register write is followed by one settling cycle, and comparisons are made only in that cycle. When the two registers match, the engine returns to idle, raises a one-cycle completion flag and keeps the result on its data output until the next start.

Top module: `gcd_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `done` is 0, `alu_out` is 0 and the engine is idle.
- R2: A high `start` seen at a clock edge while idle starts a run. `op_a` and `op_b` are captured at the following edge, which ends the load cycle.
- R3: The arithmetic sign code describes its result: 2'b00 means zero, 2'b01 means positive (for a subtraction, the minuend is larger) and 2'b10 means negative. The code 2'b11 never occurs.
- R4: Every cycle that writes a working register (load, write-A, write-B) is followed by exactly one settling cycle. The next comparison is made in that settling cycle.
- R5: When register A is larger than B, A is replaced by A−B and B keeps its value. When B is larger, B is replaced by B−A and A keeps its value.
- R6: While idle, no register is written and `alu_out` equals register A. It therefore keeps the last result unchanged until the next start, whatever `op_a` and `op_b` do.
- R7: When both registers are equal, the engine returns to idle. `done` is then high for exactly one cycle, and `alu_out` at that time is the GCD of the operands.
- R8: Counting from the edge that samples `start`, `done` is first seen high 2+2·S edges later, where S is the number of subtractions the algorithm performs (for example, 9 and 15 take three subtractions, 15→6, 9→3, 6→3, and give 3 after 8 edges).
- R9: A `start` pulse during a run is ignored, and the run in progress finishes with its own result and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | One-cycle start pulse, honoured only while idle |
| op_a | input | WIDTH | First operand, nonzero |
| op_b | input | WIDTH | Second operand, nonzero |
| alu_out | output | WIDTH | Arithmetic unit output; holds the GCD while idle |
| done | output | 1 | One-cycle pulse when a run completes |

## Verification
The bench builds the engine with WIDTH set to 5. At that width, every pair of nonzero operands (31 by 31) can be run back to back within the cycle budget. Both the result and the exact latency are checked against a GCD and a subtraction count worked out arithmetically in the bench. The sweep reaches the extremes of the loop: equal operands with no subtraction, and 1 against 31 with the longest subtraction chain. It also covers both branches of the comparison and the hold of the result between runs. Directed runs add the nine-and-fifteen trace and a start pulse injected during a long run.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_WR_A   = 3'd3,
    ST_WR_B   = 3'd4
  } ctl_state_e;

  typedef enum logic [1:0] {
    OP_PASS_A  = 2'b00,
    OP_A_SUB_B = 2'b01,
    OP_B_SUB_A = 2'b10,
    OP_PASS_B  = 2'b11
  } alu_op_e;

  localparam logic [1:0] SGN_ZERO = 2'b00;
  localparam logic [1:0] SGN_POS  = 2'b01;
  localparam logic [1:0] SGN_NEG  = 2'b10;

  typedef enum logic {
    SRC_INPUT = 1'b0,
    SRC_ALU   = 1'b1
  } reg_src_e;

  typedef struct packed {
    reg_src_e sel_a;
    reg_src_e sel_b;
    logic     wr_a;
    logic     wr_b;
    alu_op_e  op;
  } dp_ctl_t;

endpackage

// File: rtl/gcd_rst_sync.sv
module gcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gcd_alu.sv
module gcd_alu
  import gcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_op_e          op,
  output logic [WIDTH-1:0] result,
  output logic [1:0]       sign
);

  localparam int EXT = WIDTH + 1;

  logic [EXT-1:0] diff_ab;
  logic [EXT-1:0] diff_ba;
  logic [EXT-1:0] wide;

  assign diff_ab = {1'b0, a} - {1'b0, b};
  assign diff_ba = {1'b0, b} - {1'b0, a};

  always_comb begin
    unique case (op)
      OP_PASS_A:  wide = {1'b0, a};
      OP_A_SUB_B: wide = diff_ab;
      OP_B_SUB_A: wide = diff_ba;
      OP_PASS_B:  wide = {1'b0, b};
      default:    wide = {1'b0, a};
    endcase
  end

  assign result = wide[WIDTH-1:0];

  always_comb begin
    if (wide[EXT-1])            sign = SGN_NEG;
    else if (wide == '0)        sign = SGN_ZERO;
    else                        sign = SGN_POS;
  end

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
  import gcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dp_ctl_t          ctl,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic [WIDTH-1:0] reg_a,
  output logic [WIDTH-1:0] reg_b,
  output logic [WIDTH-1:0] result,
  output logic [1:0]       sign
);

  logic [WIDTH-1:0] a_q, b_q;
  logic [WIDTH-1:0] a_d, b_d;

  gcd_alu #(.WIDTH(WIDTH)) i_alu (
    .a      (a_q),
    .b      (b_q),
    .op     (ctl.op),
    .result (result),
    .sign   (sign)
  );

  assign a_d = (ctl.sel_a == SRC_ALU) ? result : in_a;
  assign b_d = (ctl.sel_b == SRC_ALU) ? result : in_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        a_q <= '0;
    else if (ctl.wr_a) a_q <= a_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        b_q <= '0;
    else if (ctl.wr_b) b_q <= b_d;
  end

  assign reg_a = a_q;
  assign reg_b = b_q;

endmodule

// File: rtl/gcd_ctl_fsm.sv
module gcd_ctl_fsm
  import gcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] sign,
  output dp_ctl_t    ctl,
  output ctl_state_e state,
  output logic       done
);

  ctl_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_LOAD;
      ST_LOAD:   state_d = ST_SETTLE;
      ST_WR_A:   state_d = ST_SETTLE;
      ST_WR_B:   state_d = ST_SETTLE;
      ST_SETTLE: begin
        if (sign == SGN_POS)      state_d = ST_WR_A;
        else if (sign == SGN_NEG) state_d = ST_WR_B;
        else                      state_d = ST_IDLE;
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  assign done_d = (state_q == ST_SETTLE) && (sign == SGN_ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    ctl.sel_a = SRC_INPUT;
    ctl.sel_b = SRC_INPUT;
    ctl.wr_a  = 1'b0;
    ctl.wr_b  = 1'b0;
    ctl.op    = OP_PASS_A;
    unique case (state_q)
      ST_IDLE:   ctl.op = OP_PASS_A;
      ST_LOAD: begin
        ctl.wr_a = 1'b1;
        ctl.wr_b = 1'b1;
      end
      ST_SETTLE: ctl.op = OP_A_SUB_B;
      ST_WR_A: begin
        ctl.op    = OP_A_SUB_B;
        ctl.sel_a = SRC_ALU;
        ctl.wr_a  = 1'b1;
      end
      ST_WR_B: begin
        ctl.op    = OP_B_SUB_A;
        ctl.sel_b = SRC_ALU;
        ctl.wr_b  = 1'b1;
      end
      default:   ctl.op = OP_PASS_A;
    endcase
  end

  assign state = state_q;
  assign done  = done_q;

endmodule

// File: rtl/gcd_unit.sv
module gcd_unit
  import gcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] alu_out,
  output logic             done
);

  logic             rst_n_int;
  dp_ctl_t          ctl;
  ctl_state_e       state;
  logic [1:0]       sign;
  logic [WIDTH-1:0] reg_a, reg_b;

  gcd_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  gcd_ctl_fsm i_fsm (
    .clk   (clk),
    .rst_n (rst_n_int),
    .start (start),
    .sign  (sign),
    .ctl   (ctl),
    .state (state),
    .done  (done)
  );

  gcd_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .ctl    (ctl),
    .in_a   (op_a),
    .in_b   (op_b),
    .reg_a  (reg_a),
    .reg_b  (reg_b),
    .result (alu_out),
    .sign   (sign)
  );

endmodule

// File: rtl/gcd_unit_chk.sv
module gcd_unit_chk
  import gcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic [WIDTH-1:0] alu_out,
  input ctl_state_e       state,
  input logic [WIDTH-1:0] reg_a,
  input logic [WIDTH-1:0] reg_b,
  input logic [1:0]       sign
);

  AST_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETTLE && sign == SGN_POS) |-> (reg_a > reg_b)); // R3
  AST_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETTLE && sign == SGN_NEG) |-> (reg_a < reg_b)); // R3
  AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETTLE && sign == SGN_ZERO) |-> (reg_a == reg_b)); // R3
  AST_SIGN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sign != 2'b11); // R3
  AST_WRITE_THEN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD || state == ST_WR_A || state == ST_WR_B) |=> (state == ST_SETTLE)); // R4
  AST_SUB_A: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_A) |=> (reg_a == $past(reg_a - reg_b) && $stable(reg_b))); // R5
  AST_SUB_B: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_B) |=> (reg_b == $past(reg_b - reg_a) && $stable(reg_a))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> ($stable(alu_out) && alu_out == reg_a)); // R6
  AST_DONE_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_IDLE && reg_a == reg_b && alu_out == reg_a)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (state != ST_LOAD)); // R9

endmodule

bind gcd_unit gcd_unit_chk #(.WIDTH(WIDTH)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n_int),
  .start   (start),
  .done    (done),
  .alu_out (alu_out),
  .state   (state),
  .reg_a   (reg_a),
  .reg_b   (reg_b),
  .sign    (sign)
);

// File: tb/test_gcd_unit.sv
module test_gcd_unit;

  localparam int W     = 5;
  localparam int MAXV  = (1 << W) - 1;
  localparam int LIMIT = 200;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] op_a, op_b;
  logic [W-1:0] alu_out;
  logic         done;

  int tests, fails;
  int cycles;
  bit finished;

  gcd_unit #(.WIDTH(W)) i_gcd_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .alu_out (alu_out),
    .done    (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void ref_gcd(input int x, input int y, output int g, output int steps);
    steps = 0;
    while (x != y) begin
      if (x > y) x = x - y;
      else       y = y - x;
      steps++;
    end
    g = x;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // run one computation; optionally inject a start pulse mid-run (R9)
  task automatic run(input int a, input int b, input int inject_at, input bit full);
    int g, s, n;
    int held;
    ref_gcd(a, b, g, s);
    @(negedge clk);
    op_a  = W'(a);
    op_b  = W'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < LIMIT) begin
      if (n == inject_at) begin
        op_a  = W'(4);
        op_b  = W'(6);
        start = 1'b1;
      end else if (n == inject_at + 1) begin
        start = 1'b0;
        op_a  = W'(a);
        op_b  = W'(b);
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check("R7 gcd result", int'(alu_out), g);
    check("R8 latency", n, 3 + 2 * s);
    if (full) begin
      held = int'(alu_out);
      op_a = W'(~a);
      op_b = W'(~b);
      @(negedge clk);
      check("R7 done single cycle", int'(done), 0);
      @(negedge clk);
      check("R6 idle hold", int'(alu_out), held);
    end
  endtask

  initial begin
    tests = 0;
    fails = 0;
    finished = 0;
    rst_n = 1'b0;
    start = 1'b0;
    op_a  = '0;
    op_b  = '0;
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 0);
    check("R1 reset alu_out", int'(alu_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release done", int'(done), 0);
    check("R1 after release alu_out", int'(alu_out), 0);
    // R2: start ignored while reset synchronizer still holds; then operands in
    repeat (3) @(negedge clk);

    // directed: nine and fifteen, three subtractions (R8, R5, R2)
    run(9, 15, -1, 1);
    // R9: start during a long run is ignored
    run(1, 31, 20, 1);
    // R4/R5 both branches and equal operands
    run(31, 1, -1, 1);
    run(7, 7, -1, 1);

    // exhaustive sweep of nonzero operand pairs
    for (int a = 1; a <= MAXV; a++) begin
      for (int b = 1; b <= MAXV; b++) begin
        run(a, b, -1, (a % 8) == 0);
      end
    end
    finish_run();
  end

  // watchdog
  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
        finish_run();
      end
    end
  end

endmodule